// File: doc/BRIEF.md
# Counter-Addressed Serial Bit Latch

This block gathers a byte one bit at a time. A single data input is written into an array of eight one-bit entries, and an internal address counter picks the entry that receives it. A write strobe opens the selected entry while it is high. A separate increment input steps the counter on its falling edge, so the host writes bit 0, steps, writes bit 1, and so on. The whole array is shown at once on a parallel output, gated by an active-low output enable. A drive-enable output stands in for the three-state buffers.

When a strobe ends while the counter points at the last entry, a full flag goes active. The flag is modelled as a pull-down request for an open-drain line, so several blocks can share one wired flag. It stays active until master reset, even after the counter wraps back to entry 0. The strobe and increment inputs are asynchronous to the system clock. They, and the data bit, pass through a two-flop synchroniser. Every edge decision is made on the synchronised copies.

Two small state machines do the control work. The strobe tracker has the states STB_LOW and STB_HIGH. It moves from STB_LOW to STB_HIGH when the synchronised strobe is seen high, and from STB_HIGH to STB_LOW when it is seen low, which is the strobe-end event. The flag machine has the states FLAG_RELEASED and FLAG_HELD. It moves from FLAG_RELEASED to FLAG_HELD on a strobe-end event while the counter is at the last entry. It leaves FLAG_HELD only through reset.

Top module: `slatch_serial_byte`

## Requirements
- R1: The address counter resets to 0 and advances by one on each falling edge of `incr_in`, wrapping from 7 to 0. A rising edge of `incr_in` does not move it.
- R2: While the synchronised strobe is high, the entry selected by the counter takes the synchronised data bit on every clock, so it follows the data. All other entries hold.
- R3: While the strobe is low, no entry changes, whatever `data_in` does.
- R4: While `rst_n` is low, all entries read 0, the counter is 0 and the full flag is released (`full_pd` = 0, `full_n` = 1).
- R5: A falling edge of the strobe with the counter at 7 makes the flag active (`full_pd` = 1, `full_n` = 0). A falling strobe at any other address leaves the flag released.
- R6: Once active, the flag stays active through further strobes, increments and the counter wrap, until reset.
- R7: With `oe_n` = 0, `drive_en` = 1 and `par_out[i]` equals entry i, where entry i is the one written when the counter held i. With `oe_n` = 1, `drive_en` = 0 and `par_out` reads all zeros, which marks the high-impedance state. These outputs follow `oe_n` without a clock.
- R8: A change of `strobe_in`, `incr_in` or `data_in` takes effect on the third rising clock edge after it: two synchroniser edges, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous assertion |
| data_in | input | 1 | Serial data bit |
| strobe_in | input | 1 | Write strobe, active high |
| incr_in | input | 1 | Address step, acts on its falling edge |
| oe_n | input | 1 | Active-low output enable |
| par_out | output | 8 | Parallel word; bit i is entry i; zero while not driven |
| drive_en | output | 1 | High when par_out should be driven onto the bus |
| full_pd | output | 1 | Open-drain pull-down request, high when full is active |
| full_n | output | 1 | Active-low full flag level |

## Verification
Every input change is due at the registers on the third rising edge after it. The bench drives inputs on falling edges and waits four full cycles before it samples, so each check falls one cycle after the due edge. One directed check samples after the second edge and after the third edge, which pins the latency to exactly three edges. The output-enable results are combinational, so the bench samples them 1 ns after it changes `oe_n`, still away from any clock edge.

// File: rtl/slatch_pkg.sv
package slatch_pkg;
    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } stb_state_t;

    typedef enum logic {
        FLAG_RELEASED = 1'b0,
        FLAG_HELD     = 1'b1
    } flag_state_t;
endpackage

// File: rtl/slatch_sync.sv
module slatch_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/slatch_ctrl.sv
module slatch_ctrl
    import slatch_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_s,
    input  logic              incr_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic              full_pd
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    stb_state_t  stb_state, stb_next;
    flag_state_t flag_state, flag_next;
    logic        incr_q;
    logic        incr_fall;
    logic        stb_end;

    // Strobe tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_state <= STB_LOW;
        else        stb_state <= stb_next;
    end

    // Strobe tracker: next state and outputs
    always_comb begin
        stb_next = stb_state;
        stb_end  = 1'b0;
        unique case (stb_state)
            STB_LOW: begin
                if (strobe_s) stb_next = STB_HIGH;
            end
            STB_HIGH: begin
                if (!strobe_s) begin
                    stb_next = STB_LOW;
                    stb_end  = 1'b1;
                end
            end
        endcase
    end

    assign wr_en = strobe_s;

    // Increment edge detector and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) incr_q <= 1'b0;
        else        incr_q <= incr_s;
    end

    assign incr_fall = incr_q && !incr_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (incr_fall) begin
            if (addr == LAST_ADDR) addr <= '0;
            else                   addr <= addr + 1'b1;
        end
    end

    // Full flag machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_state <= FLAG_RELEASED;
        else        flag_state <= flag_next;
    end

    // Full flag machine: next state and outputs
    always_comb begin
        flag_next = flag_state;
        full_pd   = 1'b0;
        unique case (flag_state)
            FLAG_RELEASED: begin
                if (stb_end && addr == LAST_ADDR) flag_next = FLAG_HELD;
            end
            FLAG_HELD: begin
                full_pd = 1'b1;
            end
        endcase
    end

    // R1: the counter steps by one (with wrap) on a falling increment
    a_r1_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        incr_fall |=> addr == (($past(addr) == LAST_ADDR) ? '0 : ADDR_W'($past(addr) + 1'b1)));

    // R1: without a falling increment the counter holds
    a_r1_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !incr_fall |=> $stable(addr));

    // R5: the flag can only rise after a strobe end at the last address
    a_r5_full_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_pd) |-> $past(addr) == LAST_ADDR);

    // R6: the flag is sticky until reset
    a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        full_pd |=> full_pd);
endmodule

// File: rtl/slatch_bit_array.sv
module slatch_bit_array #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [DEPTH-1:0]  bits
);
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                            bits[i] <= 1'b0;
                else if (wr_en && addr == ADDR_W'(i))  bits[i] <= din;
            end
        end
    endgenerate

    // R3: nothing changes while the strobe is low
    a_r3_hold_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bits));

    // R2: a write touches only the addressed entry
    a_r2_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((bits ^ $past(bits)) & ~(DEPTH'(1) << $past(addr))) == '0);

    // R4: leaving reset, every entry reads zero
    a_r4_clear_on_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> bits == '0);
endmodule

// File: rtl/slatch_serial_byte.sv
module slatch_serial_byte #(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_in,
    input  logic             strobe_in,
    input  logic             incr_in,
    input  logic             oe_n,
    output logic [DEPTH-1:0] par_out,
    output logic             drive_en,
    output logic             full_pd,
    output logic             full_n
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic [2:0]        raw_in;
    logic [2:0]        sync_in;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DEPTH-1:0]  bits;

    assign raw_in = {incr_in, strobe_in, data_in};

    slatch_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (sync_in)
    );

    slatch_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (sync_in[1]),
        .incr_s   (sync_in[2]),
        .wr_en    (wr_en),
        .addr     (addr),
        .full_pd  (full_pd)
    );

    slatch_bit_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .din   (sync_in[0]),
        .bits  (bits)
    );

    always_comb begin
        drive_en = !oe_n;
        par_out  = oe_n ? '0 : bits;
        full_n   = !full_pd;
    end

    // R7: the word is never driven while the enable is high
    a_r7_hiz_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drive_en && par_out == '0));

    // R4: during reset the flag is released
    a_r4_flag_released: assert property (@(posedge clk)
        !rst_n |-> (full_n && !full_pd));
endmodule

// File: tb/slatch_serial_byte_tb.sv
module slatch_serial_byte_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic       strobe_in = 1'b0;
    logic       incr_in = 1'b0;
    logic       oe_n = 1'b1;
    logic [7:0] par_out;
    logic       drive_en;
    logic       full_pd;
    logic       full_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_bits;
    int         m_addr;
    bit         m_full;

    always #10 clk = ~clk;

    slatch_serial_byte u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .strobe_in (strobe_in),
        .incr_in   (incr_in),
        .oe_n      (oe_n),
        .par_out   (par_out),
        .drive_en  (drive_en),
        .full_pd   (full_pd),
        .full_n    (full_n)
    );

    function automatic logic [7:0] exp_word(bit en_n);
        return en_n ? 8'h00 : m_bits;
    endfunction

    function automatic logic [1:0] exp_flag();
        return m_full ? 2'b10 : 2'b01;   // {full_pd, full_n}
    endfunction

    task automatic wait_cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(string req);
        oe_n = 1'b0;
        #1;
        check(req, {23'd0, drive_en, par_out}, {23'd0, 1'b1, exp_word(1'b0)});
        check(req, {30'd0, full_pd, full_n}, {30'd0, exp_flag()});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        m_bits = '0; m_addr = 0; m_full = 0;
        oe_n = 1'b0;
        #1;
        check("R4", {22'd0, full_pd, full_n, par_out}, {22'd0, 2'b01, 8'h00});
        @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic write_bit(bit d);
        data_in = d;
        wait_cyc(4);
        strobe_in = 1'b1;
        wait_cyc(4);
        m_bits[m_addr] = d;
        strobe_in = 1'b0;
        wait_cyc(4);
        if (m_addr == 7) m_full = 1;
    endtask

    task automatic step_addr();
        incr_in = 1'b1;
        wait_cyc(4);
        check_state("R1 rising increment leaves state");
        incr_in = 1'b0;
        wait_cyc(4);
        m_addr = (m_addr + 1) % 8;
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pattern;
        void'($urandom(32'h5eed_c0de));
        m_bits = '0; m_addr = 0; m_full = 0;
        wait_cyc(2);
        do_reset();

        // R7: disabled outputs
        oe_n = 1'b1;
        #1;
        check("R7 high-Z", {23'd0, drive_en, par_out}, 32'd0);

        // Directed: write 0xA5 LSB first, full only after the eighth strobe
        pattern = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            write_bit(pattern[i]);
            check_state("R2 serial write");
            if (i == 6) check("R5 not full after seventh strobe", {31'd0, full_pd}, 32'd0);
            if (i == 7) check("R5 full after eighth strobe", {31'd0, full_pd}, 32'd1);
            if (i < 7) step_addr();
        end
        check("R7 parallel A5", {24'd0, par_out}, 32'hA5);
        oe_n = 1'b1;
        #1;
        check("R7 high-Z after load", {23'd0, drive_en, par_out}, 32'd0);

        // R6: wrap keeps full
        step_addr();
        check("R1 wrap to 0", m_addr, 0);
        write_bit(1'b0);
        check_state("R6 full sticky after wrap");
        check("R1 write after wrap lands on bit0", {24'd0, par_out}, 32'hA4);

        // R3: data wiggle with strobe low
        for (int k = 0; k < 6; k++) begin
            data_in = ~data_in;
            wait_cyc(2);
        end
        wait_cyc(3);
        check_state("R3 data ignored while strobe low");

        // R8: latency of exactly three edges
        step_addr();                       // address 1, entry holds 0
        data_in = 1'b1;
        wait_cyc(4);
        m_bits[m_addr] = 1'b0;
        oe_n = 1'b0;
        strobe_in = 1'b1;
        wait_cyc(2);
        #1;
        check("R8 not yet after two edges", {31'd0, par_out[1]}, 32'd0);
        @(negedge clk);
        #1;
        check("R8 written on third edge", {31'd0, par_out[1]}, 32'd1);
        // R2: entry follows data while strobe stays high
        data_in = 1'b0;
        wait_cyc(4);
        check("R2 follows data while open", {31'd0, par_out[1]}, 32'd0);
        strobe_in = 1'b0;
        wait_cyc(4);
        m_bits[1] = 1'b0;
        check_state("R2 after follow");

        // Reset clears everything
        do_reset();
        check_state("R4 after reset");
        write_bit(1'b1);
        check("R4 counter back at 0", {24'd0, par_out}, 32'h01);

        // R5: strobe end at other addresses keeps flag released
        for (int i = 0; i < 3; i++) begin
            step_addr();
            write_bit(1'b1);
        end
        check("R5 released at address 3", {31'd0, full_pd}, 32'd0);

        // Constrained random
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 3) begin
                write_bit(1'($urandom_range(0, 1)));
                check_state("R2 random write");
            end else if (op <= 6) begin
                step_addr();
                check_state("R1 random step");
            end else if (op == 7) begin
                data_in = 1'($urandom_range(0, 1));
                wait_cyc(4);
                check_state("R3 random data while low");
            end else if (op == 8) begin
                oe_n = 1'b1;
                #1;
                check("R7 random high-Z", {23'd0, drive_en, par_out}, 32'd0);
                check("R6 random flag", {30'd0, full_pd, full_n}, {30'd0, exp_flag()});
            end else begin
                if ($urandom_range(0, 3) == 0) begin
                    do_reset();
                    check_state("R4 random reset");
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule